// File: doc/BRIEF.md
# Victim Store and Cast-Out Queue

This block sits beside a set-associative L1 and catches every line the L1 evicts. Storage is a handful of fully associative entries. When the L1 misses, it probes this block with the line address. On a match the entry is handed back, with its data and its modified flag, and leaves this block, so the line lives in exactly one place. A set that overflows its ways therefore gains one more way, for as long as the sets overflowing at the same moment do not outnumber the entries.

The same entries also form the queue of modified lines bound for the next level. A drain engine takes the oldest modified entry, offers it on a valid/ready port and holds it there until the next level accepts it. Afterwards the entry stays resident as a clean copy. Insertion goes to a free entry first. If there is none, the oldest clean entry is overwritten. If every entry is full and modified, `ev_ready` drops until a write-back completes.

The drain engine has two states. WB_IDLE: nothing is offered. It leaves for WB_BUSY when any modified entry exists, and on that edge it latches the oldest one. WB_BUSY: `wb_valid` is high with the latched line. It returns to WB_IDLE on the edge where `wb_ready` is high.

Top module: `victim_wb_cache`

## Requirements
- R1: While `lk_valid` is high and `lk_addr` equals the address of a resident entry, `lk_hit` is 1 in the same cycle, and `lk_data` and `lk_dirty` carry that entry's contents. Otherwise `lk_hit` is 0.
- R2: A lookup hit removes the entry at the clock edge that ends the lookup, so a later lookup of the same address misses.
- R3: Every eviction accepted (`ev_valid` and `ev_ready` both high at an edge) becomes resident, with its data and its `ev_dirty` flag, and a later lookup of it hits.
- R4: An eviction fills a free entry while one exists. When all entries are full, it overwrites the clean entry that was inserted earliest.
- R5: When all entries are resident and modified, `ev_ready` is 0. It returns to 1 after the next write-back handshake.
- R6: Modified entries are offered on the write-back port in insertion order, each exactly once, with `wb_addr` and `wb_data` equal to the inserted line.
- R7: While `wb_valid` is 1 and `wb_ready` is 0, `wb_valid`, `wb_addr` and `wb_data` hold their values into the next cycle.
- R8: After its write-back handshake an entry stays resident. A lookup of it hits with `lk_dirty` = 0.
- R9: A lookup that matches the line currently offered for write-back hits with `lk_dirty` = 1 and removes the entry. The offer stays on the port unchanged until it is accepted.
- R10: A line inserted with `ev_dirty` = 0 is never offered on the write-back port.
- R11: After reset no entry is resident, `wb_valid` is 0 and `ev_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Eviction offered by the L1 |
| ev_ready | output | 1 | Eviction can be accepted this cycle |
| ev_addr | input | ADDR_W | Line address of the evicted line |
| ev_data | input | LINE_BYTES*8 | Line data of the evicted line |
| ev_dirty | input | 1 | Evicted line is modified |
| lk_valid | input | 1 | Lookup probe active |
| lk_addr | input | ADDR_W | Line address probed |
| lk_hit | output | 1 | Probe matched a resident entry |
| lk_dirty | output | 1 | Modified flag of the matched entry |
| lk_data | output | LINE_BYTES*8 | Data of the matched entry |
| wb_valid | output | 1 | Write-back line offered to the next level |
| wb_ready | input | 1 | Next level accepts the offered line |
| wb_addr | output | ADDR_W | Line address being written back |
| wb_data | output | LINE_BYTES*8 | Line data being written back |

## Verification
The assertions assume that the L1 never evicts a line that is already resident here. Under that assumption each address matches at most one entry, and both the single-match property and the removal property rely on it. The stimulus keeps to this by using a distinct address for every line and by removing each resident line through a lookup before that address is used again. The bench also never probes and evicts the same address in one cycle.

// File: rtl/vwb_pkg.sv
package vwb_pkg;
    typedef enum logic {
        WB_IDLE = 1'b0,
        WB_BUSY = 1'b1
    } wb_state_e;
endpackage

// File: rtl/vwb_match.sv
module vwb_match #(
    parameter int N  = 4,
    parameter int AW = 26,
    parameter int DW = 512,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         valid,
    input  logic [N-1:0]         dirty,
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [N-1:0][DW-1:0] lines,
    input  logic                 probe_valid,
    input  logic [AW-1:0]        probe_addr,
    output logic [N-1:0]         match,
    output logic                 hit,
    output logic [IW-1:0]        hit_idx,
    output logic                 hit_dirty,
    output logic [DW-1:0]        hit_data
);
    // One comparator per entry, all evaluated in parallel
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = probe_valid && valid[g] && (tags[g] == probe_addr);
    end

    assign hit = |match;

    // AND-OR selection of the matching entry
    always_comb begin
        hit_idx   = '0;
        hit_dirty = 1'b0;
        hit_data  = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                hit_idx = IW'(i);
            end
            hit_dirty = hit_dirty | (match[i] & dirty[i]);
            hit_data  = hit_data | (lines[i] & {DW{match[i]}});
        end
    end
endmodule

// File: rtl/vwb_pick.sv
module vwb_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         valid,
    input  logic [N-1:0]         dirty,
    input  logic [N-1:0][IW-1:0] age,
    output logic                 free_ok,
    output logic [IW-1:0]        free_idx,
    output logic                 clean_ok,
    output logic [IW-1:0]        clean_idx,
    output logic                 dirty_ok,
    output logic [IW-1:0]        dirty_idx
);
    // Larger age means inserted earlier; ages of resident entries are distinct
    always_comb begin
        logic [IW-1:0] clean_age;
        logic [IW-1:0] dirty_age;
        free_ok   = 1'b0;
        free_idx  = '0;
        clean_ok  = 1'b0;
        clean_idx = '0;
        dirty_ok  = 1'b0;
        dirty_idx = '0;
        clean_age = '0;
        dirty_age = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_ok  = 1'b1;
                free_idx = IW'(i);
            end
        end
        for (int i = 0; i < N; i++) begin
            if (valid[i] && !dirty[i] && (!clean_ok || age[i] > clean_age)) begin
                clean_ok  = 1'b1;
                clean_idx = IW'(i);
                clean_age = age[i];
            end
            if (valid[i] && dirty[i] && (!dirty_ok || age[i] > dirty_age)) begin
                dirty_ok  = 1'b1;
                dirty_idx = IW'(i);
                dirty_age = age[i];
            end
        end
    end
endmodule

// File: rtl/vwb_drain.sv
module vwb_drain
    import vwb_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 26,
    parameter int DW = 512,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cand_ok,
    input  logic [IW-1:0]        cand_idx,
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [N-1:0][DW-1:0] lines,
    input  logic                 kill,
    input  logic [IW-1:0]        kill_idx,
    output logic                 wb_valid,
    input  logic                 wb_ready,
    output logic [AW-1:0]        wb_addr,
    output logic [DW-1:0]        wb_data,
    output logic                 done,
    output logic [IW-1:0]        done_idx
);
    wb_state_e     state_q, state_n;
    logic [IW-1:0] pend_idx;
    logic          pend_live;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WB_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            WB_IDLE: if (cand_ok)  state_n = WB_BUSY;
            WB_BUSY: if (wb_ready) state_n = WB_IDLE;
            default: state_n = WB_IDLE;
        endcase
    end

    // Captured line; a lookup that removes the entry only kills the clean-mark
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_idx  <= '0;
            pend_live <= 1'b0;
        end else if (state_q == WB_IDLE && cand_ok) begin
            pend_idx  <= cand_idx;
            pend_live <= !(kill && kill_idx == cand_idx);
        end else if (state_q == WB_BUSY && kill && kill_idx == pend_idx) begin
            pend_live <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == WB_IDLE && cand_ok) begin
            addr_q <= tags[cand_idx];
            data_q <= lines[cand_idx];
        end
    end

    // Outputs
    always_comb begin
        wb_valid = 1'b0;
        done     = 1'b0;
        done_idx = pend_idx;
        unique case (state_q)
            WB_IDLE: ;
            WB_BUSY: begin
                wb_valid = 1'b1;
                done     = wb_ready && pend_live && !(kill && kill_idx == pend_idx);
            end
            default: ;
        endcase
    end

    assign wb_addr = addr_q;
    assign wb_data = data_q;
endmodule

// File: rtl/victim_wb_cache.sv
module victim_wb_cache #(
    parameter int ENTRIES    = 4,
    parameter int LINE_BYTES = 64,
    parameter int ADDR_W     = 26,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int IW        = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [LINE_W-1:0] ev_data,
    input  logic              ev_dirty,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic              lk_dirty,
    output logic [LINE_W-1:0] lk_data,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0] wb_data
);
    logic [ENTRIES-1:0]             valid_q, valid_n;
    logic [ENTRIES-1:0]             dirty_q, dirty_n;
    logic [ENTRIES-1:0][IW-1:0]     age_q, age_n;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0][LINE_W-1:0] line_q;

    logic [ENTRIES-1:0] lk_match;
    logic [IW-1:0]      hit_idx;
    logic               free_ok, clean_ok, dirty_ok;
    logic [IW-1:0]      free_idx, clean_idx, dirty_idx;
    logic               wb_done;
    logic [IW-1:0]      wb_done_idx;
    logic               ins, vic_rm;
    logic [IW-1:0]      ins_idx;

    vwb_match #(.N(ENTRIES), .AW(ADDR_W), .DW(LINE_W)) u_match (
        .valid      (valid_q),
        .dirty      (dirty_q),
        .tags       (tag_q),
        .lines      (line_q),
        .probe_valid(lk_valid),
        .probe_addr (lk_addr),
        .match      (lk_match),
        .hit        (lk_hit),
        .hit_idx    (hit_idx),
        .hit_dirty  (lk_dirty),
        .hit_data   (lk_data)
    );

    vwb_pick #(.N(ENTRIES)) u_pick (
        .valid    (valid_q),
        .dirty    (dirty_q),
        .age      (age_q),
        .free_ok  (free_ok),
        .free_idx (free_idx),
        .clean_ok (clean_ok),
        .clean_idx(clean_idx),
        .dirty_ok (dirty_ok),
        .dirty_idx(dirty_idx)
    );

    vwb_drain #(.N(ENTRIES), .AW(ADDR_W), .DW(LINE_W)) u_drain (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand_ok (dirty_ok),
        .cand_idx(dirty_idx),
        .tags    (tag_q),
        .lines   (line_q),
        .kill    (lk_hit),
        .kill_idx(hit_idx),
        .wb_valid(wb_valid),
        .wb_ready(wb_ready),
        .wb_addr (wb_addr),
        .wb_data (wb_data),
        .done    (wb_done),
        .done_idx(wb_done_idx)
    );

    // Insertion: free entry first, else the oldest clean one
    assign ev_ready = free_ok || clean_ok;
    assign ins      = ev_valid && ev_ready;
    assign ins_idx  = free_ok ? free_idx : clean_idx;
    assign vic_rm   = ins && !free_ok;

    // Next state: removals close the age gaps, an insertion ages every survivor
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            logic keep, dec_hit, dec_vic;
            keep    = valid_q[i]
                    && !(lk_hit && hit_idx == IW'(i))
                    && !(vic_rm && clean_idx == IW'(i));
            dec_hit = lk_hit && (age_q[hit_idx] < age_q[i]);
            dec_vic = vic_rm && !(lk_hit && hit_idx == clean_idx)
                    && (age_q[clean_idx] < age_q[i]);
            valid_n[i] = keep;
            dirty_n[i] = keep && dirty_q[i] && !(wb_done && wb_done_idx == IW'(i));
            age_n[i]   = age_q[i] - IW'(dec_hit) - IW'(dec_vic) + IW'(ins);
            if (!keep) begin
                age_n[i] = '0;
            end
            if (ins && ins_idx == IW'(i)) begin
                valid_n[i] = 1'b1;
                dirty_n[i] = ev_dirty;
                age_n[i]   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            age_q   <= '0;
        end else begin
            valid_q <= valid_n;
            dirty_q <= dirty_n;
            age_q   <= age_n;
        end
    end

    // Payload storage carries no reset
    for (genvar g = 0; g < ENTRIES; g++) begin : g_store
        always_ff @(posedge clk) begin
            if (ins && ins_idx == IW'(g)) begin
                tag_q[g]  <= ev_addr;
                line_q[g] <= ev_data;
            end
        end
    end
endmodule

// File: rtl/vwb_chk.sv
module vwb_chk #(
    parameter int N  = 4,
    parameter int AW = 26,
    parameter int DW = 512
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ev_valid,
    input logic                 ev_ready,
    input logic [AW-1:0]        ev_addr,
    input logic                 lk_valid,
    input logic [AW-1:0]        lk_addr,
    input logic                 lk_hit,
    input logic                 wb_valid,
    input logic                 wb_ready,
    input logic [AW-1:0]        wb_addr,
    input logic [DW-1:0]        wb_data,
    input logic [N-1:0]         valid_q,
    input logic [N-1:0]         dirty_q,
    input logic [N-1:0][AW-1:0] tag_q,
    input logic [N-1:0]         match
);
    logic [AW-1:0] prev_lk, prev_ev;
    logic          res_lk, res_ev;

    always_ff @(posedge clk) begin
        prev_lk <= lk_addr;
        prev_ev <= ev_addr;
    end

    always_comb begin
        res_lk = 1'b0;
        res_ev = 1'b0;
        for (int i = 0; i < N; i++) begin
            res_lk = res_lk | (valid_q[i] && tag_q[i] == prev_lk);
            res_ev = res_ev | (valid_q[i] && tag_q[i] == prev_ev);
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot0(match)); // R1

    AST_HIT_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !(ev_valid && ev_ready && ev_addr == lk_addr)) |=> !res_lk); // R2

    AST_INSERT_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> res_ev); // R3

    AST_FULL_DIRTY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_q && &dirty_q) |-> !ev_ready); // R5

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data))); // R7
endmodule

bind victim_wb_cache vwb_chk #(.N(ENTRIES), .AW(ADDR_W), .DW(LINE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_valid(ev_valid),
    .ev_ready(ev_ready),
    .ev_addr (ev_addr),
    .lk_valid(lk_valid),
    .lk_addr (lk_addr),
    .lk_hit  (lk_hit),
    .wb_valid(wb_valid),
    .wb_ready(wb_ready),
    .wb_addr (wb_addr),
    .wb_data (wb_data),
    .valid_q (valid_q),
    .dirty_q (dirty_q),
    .tag_q   (tag_q),
    .match   (lk_match)
);

// File: tb/sim_victim_wb_cache.sv
`timescale 1ns/1ps
module sim_victim_wb_cache;
    localparam int AW = 26;
    localparam int DW = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0, ev_dirty = 1'b0;
    logic [AW-1:0] ev_addr = '0;
    logic [DW-1:0] ev_data = '0;
    logic          ev_ready;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_hit, lk_dirty;
    logic [DW-1:0] lk_data;
    logic          wb_valid;
    logic          wb_ready = 1'b0;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;

    int checks = 0;
    int fails  = 0;
    int unexpected = 0;
    logic [AW-1:0] exp_q[$];

    always #4 clk = ~clk;

    victim_wb_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr),
        .ev_data(ev_data), .ev_dirty(ev_dirty),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
        .lk_dirty(lk_dirty), .lk_data(lk_data),
        .wb_valid(wb_valid), .wb_ready(wb_ready),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

    function automatic logic [DW-1:0] mk(input logic [AW-1:0] a);
        return {16{({6'd0, a} ^ 32'h5A0000C3)}};
    endfunction

    task automatic chk(input bit ok, input string req, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Driver: eviction, expected write-backs pushed in insertion order
    task automatic do_insert(input logic [AW-1:0] a, input logic d);
        @(posedge clk); #1;
        ev_valid = 1'b1; ev_addr = a; ev_dirty = d; ev_data = mk(a);
        do @(negedge clk); while (!ev_ready);
        if (d) exp_q.push_back(a);
        @(posedge clk); #1;
        ev_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [AW-1:0] a, input logic eh, input logic ed,
                             input string req);
        @(posedge clk); #1;
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        chk(lk_hit == eh, req, $sformatf("lookup %h hit=%0b exp=%0b", a, lk_hit, eh));
        if (eh) begin
            chk(lk_dirty == ed, req, $sformatf("lookup %h dirty=%0b exp=%0b", a, lk_dirty, ed));
            chk(lk_data == mk(a), req, $sformatf("lookup %h data=%h exp=%h", a, lk_data[31:0], mk(a)));
        end
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    // Monitor: scoreboard of write-backs
    always @(negedge clk) begin
        if (rst_n && wb_valid && wb_ready) begin
            if (exp_q.size() == 0) begin
                unexpected++;
                chk(1'b0, "R10", $sformatf("write-back %h act, none exp", wb_addr));
            end else begin
                logic [AW-1:0] e;
                e = exp_q.pop_front();
                chk(wb_addr == e && wb_data == mk(e), "R6",
                    $sformatf("write-back act=%h exp=%h", wb_addr, e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", "run hung act=timeout exp=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11
        chk(ev_ready == 1'b1, "R11", $sformatf("ev_ready=%0b exp=1", ev_ready));
        chk(wb_valid == 1'b0, "R11", $sformatf("wb_valid=%0b exp=0", wb_valid));
        do_lookup(26'h0000100, 1'b0, 1'b0, "R11");

        // R1 R2 R3 R8 R10: one clean, one dirty line
        wb_ready = 1'b1;
        do_insert(26'h0000A01, 1'b0);
        do_insert(26'h0000B02, 1'b1);
        repeat (6) @(posedge clk);
        do_lookup(26'h0000A01, 1'b1, 1'b0, "R1");
        do_lookup(26'h0000A01, 1'b0, 1'b0, "R2");
        do_lookup(26'h0000B02, 1'b1, 1'b0, "R8");
        do_lookup(26'h0000B02, 1'b0, 1'b0, "R2");

        // R5 R7 R6: fill with dirty lines while next level is busy
        wb_ready = 1'b0;
        do_insert(26'h0000D01, 1'b1);
        do_insert(26'h0000D02, 1'b1);
        do_insert(26'h0000D03, 1'b1);
        do_insert(26'h0000D04, 1'b1);
        @(negedge clk);
        chk(ev_ready == 1'b0, "R5", $sformatf("ev_ready=%0b exp=0", ev_ready));
        chk(wb_valid && wb_addr == 26'h0000D01, "R7",
            $sformatf("wb offer %0b/%h exp 1/%h", wb_valid, wb_addr, 26'h0000D01));
        repeat (5) @(negedge clk);
        chk(wb_valid && wb_addr == 26'h0000D01, "R7",
            $sformatf("wb offer held %0b/%h exp 1/%h", wb_valid, wb_addr, 26'h0000D01));
        @(posedge clk); #1 wb_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(ev_ready == 1'b1, "R5", $sformatf("ev_ready after drain=%0b exp=1", ev_ready));
        do_insert(26'h0000D05, 1'b1);   // R4: overwrites D01, now clean and oldest
        repeat (20) @(posedge clk);
        chk(exp_q.size() == 0, "R6", $sformatf("pending=%0d exp=0", exp_q.size()));
        do_lookup(26'h0000D01, 1'b0, 1'b0, "R4");
        do_lookup(26'h0000D02, 1'b1, 1'b0, "R8");
        do_lookup(26'h0000D03, 1'b1, 1'b0, "R3");
        do_lookup(26'h0000D04, 1'b1, 1'b0, "R3");
        do_lookup(26'h0000D05, 1'b1, 1'b0, "R3");

        // R4: clean replacement follows insertion order
        do_insert(26'h0000C01, 1'b0);
        do_insert(26'h0000C02, 1'b0);
        do_insert(26'h0000C03, 1'b0);
        do_insert(26'h0000C04, 1'b0);
        do_insert(26'h0000C05, 1'b0);
        do_insert(26'h0000C06, 1'b0);
        do_lookup(26'h0000C01, 1'b0, 1'b0, "R4");
        do_lookup(26'h0000C02, 1'b0, 1'b0, "R4");
        do_lookup(26'h0000C03, 1'b1, 1'b0, "R4");
        do_lookup(26'h0000C06, 1'b1, 1'b0, "R4");
        do_lookup(26'h0000C04, 1'b1, 1'b0, "R4");
        do_lookup(26'h0000C05, 1'b1, 1'b0, "R4");

        // R9: lookup takes the line being offered
        wb_ready = 1'b0;
        do_insert(26'h0000E01, 1'b1);
        repeat (3) @(posedge clk);
        do_lookup(26'h0000E01, 1'b1, 1'b1, "R9");
        do_lookup(26'h0000E01, 1'b0, 1'b0, "R9");
        @(negedge clk);
        chk(wb_valid && wb_addr == 26'h0000E01 && wb_data == mk(26'h0000E01), "R9",
            $sformatf("offer %0b/%h exp 1/%h", wb_valid, wb_addr, 26'h0000E01));
        @(posedge clk); #1 wb_ready = 1'b1;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R9", $sformatf("pending=%0d exp=0", exp_q.size()));
        chk(wb_valid == 1'b0, "R6", $sformatf("wb_valid=%0b exp=0", wb_valid));
        chk(unexpected == 0, "R10", $sformatf("unexpected=%0d exp=0", unexpected));
        summary();
    end
endmodule